// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block resolves a single operand of a 16-bit, eight-register minicomputer instruction. The caller presents a 6-bit operand specifier, a byte/word flag and a one-cycle start pulse. The block then runs a short sequence against a register-file read/write port and a word-wide memory read port. When it finishes, it reports one of two results:

- a register index, when the operand lives in a register;
- the final effective memory address, when the operand lives in memory.

A one-cycle done pulse marks the result.

The sequence covers everything addressing needs before the operand data itself is touched:

- pre-decrement and post-increment of the selected register;
- fetching an index word from the program counter's address, and moving the program counter past it;
- reading a deferred pointer.

The operand data access, the ALU and instruction fetch belong to the surrounding datapath.

The specifier splits into two fields. Bits 5:3 hold the mode. Bits 2:0 select the register, and register 7 is the program counter. At most one register is modified per operand. That write is presented on the write port in the done cycle, so the caller sees every side effect and the result together.

Top module: `opnd_addr_seq`

## Requirements
- R1: While reset is active and after it, with no start, `done_o`, `mem_req_o` and `rf_we_o` stay low.
- R2: Mode 0 (spec[5:3]=0) ends with `is_reg_o`=1 and `reg_idx_o` equal to spec[2:0]. It issues no memory read and no register write.
- R3: Mode 1 yields an address equal to the selected register's contents, with no register write.
- R4: Mode 2 yields the register's contents as the address, and writes back contents plus a step. The step is 1 only for a byte operation (`byte_i`=1) on registers 0 to 5; otherwise it is 2. Register 6 and register 7 always use 2.
- R5: Mode 4 subtracts the step defined in R4 from the register, writes that value back, and yields it as the address.
- R6: Modes 3 and 5 always step by 2, in both byte and word operations. Mode 3 reads a pointer at the register's address and writes back contents plus 2. Mode 5 writes back contents minus 2 and reads the pointer at that value. In both, the address is the word read.
- R7: Modes 6 and 7 read an index word at the address held in register 7, and write register 7 back as its old value plus 2. The sum is the index plus the base. The base is the selected register, except that register 7 contributes its advanced value. Mode 6 yields the sum. Mode 7 reads a word at the sum and yields that word.
- R8: Memory reads are issued in the order given in R6 and R7. `mem_req_o` and `mem_addr_o` hold steady until `mem_ack_i`. `done_o` rises exactly one cycle after the last acknowledged read, or two cycles after start when no read is needed. Arithmetic on addresses wraps modulo 2^16.
- R9: `rf_we_o` is asserted only in the done cycle, with the register index and value given by R4 to R7.
- R10: A start pulse arriving while an operand is being resolved is ignored.
- R11: `done_o` is high for exactly one cycle per operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin resolving an operand |
| spec_i | input | 6 | Operand specifier: mode in 5:3, register in 2:0 |
| byte_i | input | 1 | 1 for a byte operation, 0 for a word operation |
| rf_raddr_o | output | 3 | Register-file read index |
| rf_rdata_i | input | AW | Register-file read data, same cycle |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 3 | Register write index |
| rf_wdata_o | output | AW | Register write value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_ack_i | input | 1 | Memory read response valid |
| mem_rdata_i | input | AW | Memory read data |
| done_o | output | 1 | Result valid pulse |
| is_reg_o | output | 1 | Result is a register, not an address |
| reg_idx_o | output | 3 | Selected register index |
| ea_o | output | AW | Effective address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, register 7 as the program counter, and a single-step limit covering registers 0 to 5. With these values all 64 specifiers can be driven in byte and in word form. The register-6 alignment rule and the program-counter rules become reachable alongside the narrow byte step. The register file is preloaded with mixed values, then with all zeros and then with all ones. Those loads force pre-decrement and post-increment to wrap through zero. Memory latency varies from zero to two wait cycles, which exercises the request-hold rule and the done timing.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDREG = 2'd1,
    ST_MEMRD = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  localparam logic [2:0] M_REG   = 3'd0;
  localparam logic [2:0] M_DEF   = 3'd1;
  localparam logic [2:0] M_AINC  = 3'd2;
  localparam logic [2:0] M_AINCD = 3'd3;
  localparam logic [2:0] M_ADEC  = 3'd4;
  localparam logic [2:0] M_ADECD = 3'd5;
  localparam logic [2:0] M_IDX   = 3'd6;
  localparam logic [2:0] M_IDXD  = 3'd7;

endpackage

// File: rtl/opnd_step.sv
module opnd_step
  import opnd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int RSW       = 3,
  parameter int WIDE_FROM = 6
) (
  input  logic [2:0]     mode_i,
  input  logic [RSW-1:0] rsel_i,
  input  logic           byte_i,
  input  logic [AW-1:0]  val_i,
  output logic [AW-1:0]  inc_o,
  output logic [AW-1:0]  dec_o
);

  logic          narrow;
  logic [AW-1:0] step;

  // single-unit step only for byte auto inc/dec on low registers
  assign narrow = byte_i && (int'(rsel_i) < WIDE_FROM) &&
                  ((mode_i == M_AINC) || (mode_i == M_ADEC));
  assign step   = narrow ? AW'(1) : AW'(2);
  assign inc_o  = val_i + step;
  assign dec_o  = val_i - step;

endmodule

// File: rtl/opnd_index_add.sv
module opnd_index_add #(
  parameter int AW     = 16,
  parameter int RSW    = 3,
  parameter int PC_SEL = 7
) (
  input  logic [RSW-1:0] rsel_i,
  input  logic [AW-1:0]  reg_val_i,
  input  logic [AW-1:0]  pc_adv_i,
  input  logic [AW-1:0]  disp_i,
  output logic [AW-1:0]  sum_o
);

  logic [AW-1:0] base;

  // the program counter contributes its value after the index word
  assign base  = (rsel_i == RSW'(PC_SEL)) ? pc_adv_i : reg_val_i;
  assign sum_o = base + disp_i;

endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
  import opnd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PC_SEL    = 7,
  parameter int WIDE_FROM = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [5:0]    spec_i,
  input  logic          byte_i,
  output logic [2:0]    rf_raddr_o,
  input  logic [AW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [2:0]    rf_waddr_o,
  output logic [AW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          is_reg_o,
  output logic [2:0]    reg_idx_o,
  output logic [AW-1:0] ea_o
);

  localparam int RSW = 3;
  localparam int MW  = 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  seq_state_e     state_q, state_d;
  logic [MW-1:0]  mode_q, mode_d;
  logic [RSW-1:0] rsel_q, rsel_d;
  logic           byte_q, byte_d;
  logic [AW-1:0]  ea_q, ea_d;
  logic           isreg_q, isreg_d;
  logic           wben_q, wben_d;
  logic [RSW-1:0] wbidx_q, wbidx_d;
  logic [AW-1:0]  wbval_q, wbval_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           fidx_q, fidx_d;
  logic           cap_en;
  logic [RSW-1:0] raddr;
  logic [AW-1:0]  inc_val, dec_val, idx_sum;

  opnd_step #(.AW(AW), .RSW(RSW), .WIDE_FROM(WIDE_FROM)) u_step (
    .mode_i (mode_q),
    .rsel_i (rsel_q),
    .byte_i (byte_q),
    .val_i  (rf_rdata_i),
    .inc_o  (inc_val),
    .dec_o  (dec_val)
  );

  // base register is read while the index word is in flight
  opnd_index_add #(.AW(AW), .RSW(RSW), .PC_SEL(PC_SEL)) u_idx (
    .rsel_i    (rsel_q),
    .reg_val_i (rf_rdata_i),
    .pc_adv_i  (wbval_q),
    .disp_i    (mem_rdata_i),
    .sum_o     (idx_sum)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    rsel_d  = rsel_q;
    byte_d  = byte_q;
    ea_d    = ea_q;
    isreg_d = isreg_q;
    wben_d  = wben_q;
    wbidx_d = wbidx_q;
    wbval_d = wbval_q;
    addr_d  = addr_q;
    fidx_d  = fidx_q;
    raddr   = rsel_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d  = spec_i[5:3];
          rsel_d  = spec_i[2:0];
          byte_d  = byte_i;
          isreg_d = 1'b0;
          wben_d  = 1'b0;
          wbidx_d = spec_i[2:0];
          state_d = ST_RDREG;
        end
      end
      ST_RDREG: begin
        state_d = ST_FIN;
        if ((mode_q == M_IDX) || (mode_q == M_IDXD)) raddr = RSW'(PC_SEL);
        case (mode_q)
          M_REG: begin
            isreg_d = 1'b1;
            ea_d    = '0;
          end
          M_DEF: ea_d = rf_rdata_i;
          M_AINC: begin
            ea_d    = rf_rdata_i;
            wben_d  = 1'b1;
            wbval_d = inc_val;
          end
          M_AINCD: begin
            addr_d  = rf_rdata_i;
            wben_d  = 1'b1;
            wbval_d = inc_val;
            fidx_d  = 1'b0;
            state_d = ST_MEMRD;
          end
          M_ADEC: begin
            ea_d    = dec_val;
            wben_d  = 1'b1;
            wbval_d = dec_val;
          end
          M_ADECD: begin
            addr_d  = dec_val;
            wben_d  = 1'b1;
            wbval_d = dec_val;
            fidx_d  = 1'b0;
            state_d = ST_MEMRD;
          end
          default: begin
            addr_d  = rf_rdata_i;
            wben_d  = 1'b1;
            wbidx_d = RSW'(PC_SEL);
            wbval_d = inc_val;
            fidx_d  = 1'b1;
            state_d = ST_MEMRD;
          end
        endcase
      end
      ST_MEMRD: begin
        if (mem_ack_i) begin
          if (!fidx_q) begin
            ea_d    = mem_rdata_i;
            state_d = ST_FIN;
          end else if (mode_q == M_IDX) begin
            ea_d    = idx_sum;
            state_d = ST_FIN;
          end else begin
            addr_d  = idx_sum;
            fidx_d  = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cap_en = (state_q == ST_IDLE) ? start_i : (state_q != ST_FIN);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q  <= '0;
      rsel_q  <= '0;
      byte_q  <= 1'b0;
      ea_q    <= '0;
      isreg_q <= 1'b0;
      wben_q  <= 1'b0;
      wbidx_q <= '0;
      wbval_q <= '0;
      addr_q  <= '0;
      fidx_q  <= 1'b0;
    end else if (cap_en) begin
      mode_q  <= mode_d;
      rsel_q  <= rsel_d;
      byte_q  <= byte_d;
      ea_q    <= ea_d;
      isreg_q <= isreg_d;
      wben_q  <= wben_d;
      wbidx_q <= wbidx_d;
      wbval_q <= wbval_d;
      addr_q  <= addr_d;
      fidx_q  <= fidx_d;
    end
  end

  assign rf_raddr_o = raddr;
  assign done_o     = (state_q == ST_FIN);
  assign rf_we_o    = done_o && wben_q;
  assign rf_waddr_o = wbidx_q;
  assign rf_wdata_o = wbval_q;
  assign mem_req_o  = (state_q == ST_MEMRD);
  assign mem_addr_o = addr_q;
  assign is_reg_o   = isreg_q;
  assign reg_idx_o  = rsel_q;
  assign ea_o       = ea_q;

endmodule

// File: rtl/opnd_addr_seq_chk.sv
module opnd_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_o,
  input logic          rf_we_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          is_reg_o
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> done_o);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  done_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);

  // R2
  reg_direct_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && is_reg_o) |-> !rf_we_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!done_o && !mem_req_o && !rf_we_o));

endmodule

bind opnd_addr_seq opnd_addr_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_o     (done_o),
  .rf_we_o    (rf_we_o),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .is_reg_o   (is_reg_o)
);

// File: tb/opnd_addr_seq_bench.sv
`timescale 1ns/1ps
module opnd_addr_seq_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [5:0]    spec_i;
  logic          byte_i;
  logic [2:0]    rf_raddr_o;
  logic [AW-1:0] rf_rdata_i;
  logic          rf_we_o;
  logic [2:0]    rf_waddr_o;
  logic [AW-1:0] rf_wdata_o;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ack_i;
  logic [AW-1:0] mem_rdata_i;
  logic          done_o;
  logic          is_reg_o;
  logic [2:0]    reg_idx_o;
  logic [AW-1:0] ea_o;

  logic [AW-1:0] regs [8];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign rf_rdata_i = regs[rf_raddr_o];

  opnd_addr_seq u_opnd_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .spec_i(spec_i), .byte_i(byte_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .is_reg_o(is_reg_o), .reg_idx_o(reg_idx_o), .ea_o(ea_o)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_regs(input int pass, input int salt);
    for (int i = 0; i < 8; i++) begin
      case (pass)
        0:       regs[i] = 16'(32'h2001 + i * 32'h0246 + salt * 32'h0013);
        1:       regs[i] = 16'h0000;
        default: regs[i] = 16'hFFFF;
      endcase
    end
  endtask

  task automatic run_op(input logic [5:0] spec, input bit bop, input int lat);
    logic [2:0]  m = spec[5:3];
    logic [2:0]  r = spec[2:0];
    logic [15:0] rv = regs[spec[2:0]];
    logic [15:0] pc = regs[7];
    logic [15:0] q[$];
    logic [15:0] e_ea = '0;
    logic [15:0] e_wv = '0;
    logic [15:0] idx, base, sum;
    logic [2:0]  e_wi = spec[2:0];
    bit          e_we = 1'b0;
    bit          e_reg = 1'b0;
    int          step, nmem, waitc, last_ack;
    bit          got;
    step = (bop && r < 6 && (m == 3'd2 || m == 3'd4)) ? 1 : 2;
    case (m)
      3'd0: e_reg = 1'b1;                                              // R2
      3'd1: e_ea = rv;                                                 // R3
      3'd2: begin e_ea = rv; e_we = 1; e_wv = rv + 16'(step); end     // R4
      3'd3: begin q.push_back(rv); e_ea = memf(rv); e_we = 1; e_wv = rv + 16'd2; end  // R6
      3'd4: begin e_ea = rv - 16'(step); e_we = 1; e_wv = e_ea; end   // R5
      3'd5: begin e_wv = rv - 16'd2; q.push_back(e_wv); e_ea = memf(e_wv); e_we = 1; end // R6
      default: begin                                                   // R7
        idx = memf(pc);
        q.push_back(pc);
        e_we = 1; e_wi = 3'd7; e_wv = pc + 16'd2;
        base = (r == 3'd7) ? e_wv : rv;
        sum = base + idx;
        if (m == 3'd6) e_ea = sum;
        else begin q.push_back(sum); e_ea = memf(sum); end
      end
    endcase
    nmem = q.size();
    @(negedge clk);
    start_i = 1'b1; spec_i = spec; byte_i = bop; mem_ack_i = 1'b0;
    waitc = 0; last_ack = -1; got = 1'b0;
    for (int k = 1; k <= 40 && !got; k++) begin
      @(negedge clk);
      if (k == 1) begin start_i = 1'b1; spec_i = ~spec; byte_i = ~bop; end  // R10 spurious start
      else start_i = 1'b0;
      mem_ack_i = 1'b0;
      chk(!rf_we_o || done_o, "R9 write outside done", 32'(rf_we_o), 32'(done_o));
      if (done_o) begin
        got = 1'b1;
        chk(k == ((nmem > 0) ? last_ack + 1 : 2), "R8 done cycle", 32'(k),
            32'((nmem > 0) ? last_ack + 1 : 2));
        chk(q.size() == 0, "R8 missing memory reads", 32'(q.size()), 32'd0);
        chk(is_reg_o == e_reg, "R2 is_reg", 32'(is_reg_o), 32'(e_reg));
        if (e_reg) chk(reg_idx_o == r, "R2 reg index", 32'(reg_idx_o), 32'(r));
        else chk(ea_o == e_ea, (m >= 3'd6) ? "R7 address" : (m == 3'd3 || m == 3'd5) ?
                 "R6 address" : (m == 3'd4) ? "R5 address" : (m == 3'd2) ? "R4 address" :
                 "R3 address", 32'(ea_o), 32'(e_ea));
        chk(rf_we_o == e_we, "R9 write strobe", 32'(rf_we_o), 32'(e_we));
        if (e_we) begin
          chk(rf_waddr_o == e_wi, "R9 write index", 32'(rf_waddr_o), 32'(e_wi));
          chk(rf_wdata_o == e_wv, (m == 3'd4) ? "R5 write value" : (m == 3'd2) ?
              "R4 write value" : (m >= 3'd6) ? "R7 write value" : "R6 write value",
              32'(rf_wdata_o), 32'(e_wv));
        end
        if (rf_we_o) regs[rf_waddr_o] = rf_wdata_o;
      end else if (mem_req_o) begin
        if (waitc == lat) begin
          chk(q.size() > 0 && mem_addr_o == q[0], "R8 read address", 32'(mem_addr_o),
              (q.size() > 0) ? 32'(q[0]) : 32'hFFFF_FFFF);
          if (q.size() > 0) void'(q.pop_front());
          mem_ack_i = 1'b1;
          mem_rdata_i = memf(mem_addr_o);
          last_ack = k;
          waitc = 0;
        end else waitc++;
      end
    end
    if (!got) chk(1'b0, "R8 no done", 32'd0, 32'd1);
    @(negedge clk);
    mem_ack_i = 1'b0;
    chk(!done_o, "R11 done width", 32'(done_o), 32'd0);
    chk(!mem_req_o, "R10 restarted", 32'(mem_req_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; spec_i = '0; byte_i = 1'b0;
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    load_regs(0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!done_o && !mem_req_o && !rf_we_o, "R1 reset state",
          {29'd0, done_o, mem_req_o, rf_we_o}, 32'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!done_o && !mem_req_o && !rf_we_o, "R1 idle after reset",
          {29'd0, done_o, mem_req_o, rf_we_o}, 32'd0);
    end
    for (int pass = 0; pass < 3; pass++) begin
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s < 64; s++) begin
          load_regs(pass, s);
          run_op(6'(s), b[0], (s + pass) % 3);
        end
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule